// File: doc/BRIEF.md
# Descriptor Chain DMA Command Engine

This block runs a channel program for one DMA channel. The program is a chain of 16-byte command descriptors held in memory. The engine reads the descriptor at the command pointer and decodes its operation. It then carries out one of these: it moves words from memory to an outgoing stream, it moves words from an incoming stream to memory, it stores or loads one word, it does nothing, or it stops. Each descriptor has three two-bit control fields, for wait, interrupt and branch. Each field tests a single condition input. When a command finishes, the engine writes a status word and a residual count back into the descriptor. It then follows the chain, either to the next descriptor or to a branch target.

Software loads the command pointer while the channel is inactive. It pulses `start` to make the channel active and holds `run` high to let commands be fetched. The engine is idle between commands and fetches a new command only when both `run` and the active state are set. A stop command ends the program. A malformed command marks the channel dead. Memory is a single request/acknowledge port. A request stays asserted, with its address and data unchanged, until `mem_ack` is seen at a clock edge. Both streams use valid/ready. The outgoing stream holds `out_valid`, `out_data` and `out_last` unchanged while `out_ready` is low. The engine drives `in_ready` only when it can accept a word. An incoming word is taken on any edge where `in_valid` and `in_ready` are both high, so the source may wait as long as it needs.

Top module: `dbcmd_engine`

## Requirements
- R1: After reset, `active`, `dead`, `irq`, `mem_req`, `out_valid` and `in_ready` are low and `cmd_ptr` is zero.
- R2: The engine reads descriptor words at pointer offsets 0, 4 and 8. Word 0 holds the command word in bits 31:16 and the requested byte count in bits 15:0. Word 1 holds the data address. Word 2 holds the dependent word. Within the command word, bits 15:12 are the opcode, bits 10:8 the key, bits 5:4 the interrupt mode, bits 3:2 the branch mode and bits 1:0 the wait mode.
- R3: A `start` pulse while inactive sets `active` and clears `dead`. A pointer write (`ptr_wr`) takes effect only while inactive. No fetch begins unless `run` and `active` are both high.
- R4: Opcodes 0 and 1 send ceil(count/4) words read from ascending addresses starting at the data address. `out_last` is high only on the final word of opcode 1. Words are held unchanged under back-pressure.
- R5: Opcodes 2 and 3 write incoming words to ascending addresses until the count runs out. Opcode 3 also ends after a word that arrives with `in_last` high. Opcode 2 ignores `in_last`.
- R6: The channel is killed in these cases: an input command whose address is zero or whose key is above 3, a load or store whose key is below 5, or any opcode of 8 or higher. Killing sets `dead`, clears `active`, writes nothing back and leaves `cmd_ptr` unchanged.
- R7: Opcode 4 writes the dependent word to the data address. Opcode 5 reads the data address and writes the value read into descriptor word 2.
- R8: A satisfied wait mode stalls the engine after the command's work is done and before interrupt, branch and write-back. The stall lasts until the wait mode no longer holds.
- R9: Every mode field uses the same encoding: 0 never, 1 if `cond_in` is 1, 2 if `cond_in` is 0, 3 always. When the interrupt mode holds, `irq` pulses high for exactly one cycle.
- R10: If the branch mode holds, the next pointer is the dependent word. Otherwise the next pointer is `cmd_ptr`+16.
- R11: Write-back stores {status, residual} to pointer offset 12. The status has bit 15 = run, bit 10 = active, bit 8 = branch taken, bit 0 = `cond_in`, and every other bit zero. The residual is the number of bytes not moved for opcodes 0 to 3, and the requested count for opcodes 4 to 6.
- R12: Opcode 7 clears `active`, writes nothing back and leaves `cmd_ptr` at the stop descriptor.
- R13: `mem_req` and its address, direction and write data stay stable until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Allows command fetches while high |
| start | input | 1 | Pulse: activate the channel |
| ptr_wr | input | 1 | Load `ptr_in` into the command pointer |
| ptr_in | input | AW | New command pointer |
| cond_in | input | 1 | Condition bit tested by the mode fields |
| active | output | 1 | Channel active |
| dead | output | 1 | Channel killed by a malformed command |
| cmd_ptr | output | AW | Current command pointer |
| irq | output | 1 | One-cycle interrupt pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| out_valid | output | 1 | Outgoing stream word valid |
| out_ready | input | 1 | Outgoing stream sink ready |
| out_data | output | 32 | Outgoing stream word |
| out_last | output | 1 | Final word of a packet |
| in_valid | input | 1 | Incoming stream word valid |
| in_ready | output | 1 | Engine can accept an incoming word |
| in_data | input | 32 | Incoming stream word |
| in_last | input | 1 | Incoming end-of-packet marker |

## Verification
Some properties are checked on every cycle. A pending memory request must hold its address, direction and data until acknowledged. A stalled outgoing word must stay unchanged. `irq` must never be high for two cycles in a row. `dead` must exclude `active`. The pointer must not move while the channel is inactive and no pointer write is made. No more than one of outgoing valid, incoming ready and memory request may be high at once. Only the bench scenarios can show the rest. These are the decoded results of each mode and condition combination, the branch target versus the sequential pointer, the written-back status and residual, the early end of an input packet, the kill and stop cases, and the effect of a wait stall and of `run`.

// File: rtl/dbcmd_pkg.sv
package dbcmd_pkg;
  localparam int DW         = 32;
  localparam int BEAT_BYTES = DW / 8;
  localparam int DESC_BYTES = 16;

  localparam logic [3:0] OP_OUT_MORE = 4'd0;
  localparam logic [3:0] OP_OUT_LAST = 4'd1;
  localparam logic [3:0] OP_IN_MORE  = 4'd2;
  localparam logic [3:0] OP_IN_LAST  = 4'd3;
  localparam logic [3:0] OP_STORE    = 4'd4;
  localparam logic [3:0] OP_LOAD     = 4'd5;
  localparam logic [3:0] OP_NOP      = 4'd6;
  localparam logic [3:0] OP_STOP     = 4'd7;

  typedef enum logic [1:0] {
    CM_NEVER  = 2'd0,
    CM_IFSET  = 2'd1,
    CM_IFCLR  = 2'd2,
    CM_ALWAYS = 2'd3
  } cmode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_OUT_RD, S_OUT_TX, S_IN_RX, S_IN_WR,
    S_STW, S_LDW_RD, S_LDW_WB, S_COND, S_WB
  } state_e;

  function automatic logic [15:0] status_word(input logic run_b, input logic act_b,
                                              input logic bt_b, input logic cnd_b);
    status_word = {run_b, 4'b0000, act_b, 1'b0, bt_b, 7'b0000000, cnd_b};
  endfunction
endpackage

// File: rtl/dbcmd_cond_eval.sv
module dbcmd_cond_eval
  import dbcmd_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       cond,
  output logic       hit
);
  always_comb begin
    case (cmode_e'(mode))
      CM_NEVER:  hit = 1'b0;
      CM_IFSET:  hit = cond;
      CM_IFCLR:  hit = ~cond;
      default:   hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/dbcmd_chan_state.sv
module dbcmd_chan_state #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_in,
  input  logic          ev_kill,
  input  logic          ev_stop,
  input  logic          ev_step,
  input  logic [AW-1:0] step_ptr,
  output logic          active,
  output logic          dead,
  output logic [AW-1:0] cmd_ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      dead    <= 1'b0;
      cmd_ptr <= '0;
    end else begin
      if (ev_kill) begin
        dead   <= 1'b1;
        active <= 1'b0;
      end else if (ev_stop) begin
        active <= 1'b0;
      end else if (start && !active) begin
        active <= 1'b1;
        dead   <= 1'b0;
      end
      if (ev_step)
        cmd_ptr <= step_ptr;
      else if (ptr_wr && !active)
        cmd_ptr <= ptr_in;
    end
  end
endmodule

// File: rtl/dbcmd_seq.sv
module dbcmd_seq
  import dbcmd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          active,
  input  logic [AW-1:0] cmd_ptr,
  input  logic          cond_in,
  input  logic          hit_wait,
  input  logic          hit_br,
  input  logic          hit_intr,
  output logic [5:0]    ctl,
  output logic          ev_kill,
  output logic          ev_stop,
  output logic          ev_step,
  output logic [AW-1:0] step_ptr,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last
);
  localparam int CW = 16;
  localparam logic [CW-1:0] BEAT_C = CW'(BEAT_BYTES);

  state_e        state;
  logic [1:0]    fidx;
  logic [3:0]    op;
  logic [2:0]    key;
  logic [CW-1:0] req_cnt;
  logic [CW-1:0] res;
  logic [AW-1:0] cur;
  logic [DW-1:0] dep;
  logic [DW-1:0] beat;
  logic          in_end;
  logic          bt;
  logic          cnd_lat;

  logic          is_last;
  logic          kill_cond;
  logic [CW-1:0] res_dec;

  assign is_last = op[0];
  assign res_dec = (res > BEAT_C) ? (res - BEAT_C) : '0;

  always_comb begin
    kill_cond = 1'b0;
    if (op == OP_IN_MORE || op == OP_IN_LAST)
      kill_cond = (cur == '0) || (key > 3'd3);
    else if (op == OP_STORE || op == OP_LOAD)
      kill_cond = (key < 3'd5);
    else if (op > OP_STOP)
      kill_cond = 1'b1;
  end

  assign ev_kill  = (state == S_DECODE) && kill_cond;
  assign ev_stop  = (state == S_DECODE) && (op == OP_STOP);
  assign ev_step  = (state == S_WB) && mem_ack;
  assign step_ptr = bt ? dep[AW-1:0] : (cmd_ptr + AW'(DESC_BYTES));

  assign out_valid = (state == S_OUT_TX);
  assign out_data  = beat;
  assign out_last  = is_last && (res <= BEAT_C);
  assign in_ready  = (state == S_IN_RX) && (res != '0) && !in_end;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    case (state)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cmd_ptr + AW'({fidx, 2'b00});
      end
      S_OUT_RD: mem_req = (res != '0);
      S_LDW_RD: mem_req = 1'b1;
      S_IN_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = beat;
      end
      S_STW: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = dep;
      end
      S_LDW_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cmd_ptr + AW'(8);
        mem_wdata = dep;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cmd_ptr + AW'(12);
        mem_wdata = {status_word(run, active, bt, cnd_lat), res};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      fidx    <= '0;
      op      <= '0;
      key     <= '0;
      ctl     <= '0;
      req_cnt <= '0;
      res     <= '0;
      cur     <= '0;
      dep     <= '0;
      beat    <= '0;
      in_end  <= 1'b0;
      bt      <= 1'b0;
      cnd_lat <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        S_IDLE: begin
          fidx <= '0;
          if (run && active) state <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          case (fidx)
            2'd0: begin
              op      <= mem_rdata[31:28];
              key     <= mem_rdata[26:24];
              ctl     <= mem_rdata[21:16];
              req_cnt <= mem_rdata[15:0];
            end
            2'd1:    cur <= mem_rdata[AW-1:0];
            default: dep <= mem_rdata;
          endcase
          fidx <= fidx + 2'd1;
          if (fidx == 2'd2) state <= S_DECODE;
        end
        S_DECODE: begin
          res    <= req_cnt;
          in_end <= 1'b0;
          if (kill_cond) state <= S_IDLE;
          else begin
            case (op)
              OP_OUT_MORE, OP_OUT_LAST: state <= S_OUT_RD;
              OP_IN_MORE, OP_IN_LAST:   state <= S_IN_RX;
              OP_STORE:                 state <= S_STW;
              OP_LOAD:                  state <= S_LDW_RD;
              OP_NOP:                   state <= S_COND;
              default:                  state <= S_IDLE;
            endcase
          end
        end
        S_OUT_RD: begin
          if (res == '0) state <= S_COND;
          else if (mem_ack) begin
            beat  <= mem_rdata;
            state <= S_OUT_TX;
          end
        end
        S_OUT_TX: if (out_ready) begin
          cur   <= cur + AW'(BEAT_BYTES);
          res   <= res_dec;
          state <= S_OUT_RD;
        end
        S_IN_RX: begin
          if (res == '0 || in_end) state <= S_COND;
          else if (in_valid) begin
            beat   <= in_data;
            in_end <= is_last && in_last;
            state  <= S_IN_WR;
          end
        end
        S_IN_WR: if (mem_ack) begin
          cur   <= cur + AW'(BEAT_BYTES);
          res   <= res_dec;
          state <= S_IN_RX;
        end
        S_STW: if (mem_ack) state <= S_COND;
        S_LDW_RD: if (mem_ack) begin
          dep   <= mem_rdata;
          state <= S_LDW_WB;
        end
        S_LDW_WB: if (mem_ack) state <= S_COND;
        S_COND: if (!hit_wait) begin
          irq     <= hit_intr;
          bt      <= hit_br;
          cnd_lat <= cond_in;
          state   <= S_WB;
        end
        S_WB: if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbcmd_engine.sv
module dbcmd_engine
  import dbcmd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_in,
  input  logic          cond_in,
  output logic          active,
  output logic          dead,
  output logic [AW-1:0] cmd_ptr,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last
);
  localparam int NFIELD = 3;

  logic [5:0]        ctl;
  logic [NFIELD-1:0] hits;
  logic              ev_kill, ev_stop, ev_step;
  logic [AW-1:0]     step_ptr;

  for (genvar g = 0; g < NFIELD; g++) begin : g_mode
    dbcmd_cond_eval u_eval (
      .mode (ctl[2*g +: 2]),
      .cond (cond_in),
      .hit  (hits[g])
    );
  end

  dbcmd_chan_state #(.AW(AW)) u_state (
    .clk(clk), .rst_n(rst_n), .start(start), .ptr_wr(ptr_wr), .ptr_in(ptr_in),
    .ev_kill(ev_kill), .ev_stop(ev_stop), .ev_step(ev_step), .step_ptr(step_ptr),
    .active(active), .dead(dead), .cmd_ptr(cmd_ptr)
  );

  dbcmd_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .active(active), .cmd_ptr(cmd_ptr),
    .cond_in(cond_in), .hit_wait(hits[0]), .hit_br(hits[1]), .hit_intr(hits[2]),
    .ctl(ctl), .ev_kill(ev_kill), .ev_stop(ev_stop), .ev_step(ev_step),
    .step_ptr(step_ptr), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last)
  );
endmodule

// File: rtl/dbcmd_engine_chk.sv
module dbcmd_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ptr_wr,
  input logic          active,
  input logic          dead,
  input logic [AW-1:0] cmd_ptr,
  input logic          irq,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_data,
  input logic          out_last,
  input logic          in_ready
);
  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6
  dead_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dead |-> !active);

  // R3
  ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !ptr_wr |=> $stable(cmd_ptr));

  // R5
  xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, in_ready, mem_req}));
endmodule

bind dbcmd_engine dbcmd_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/dbcmd_engine_bench.sv
module dbcmd_engine_bench;
  localparam int AW = 32;
  localparam logic [31:0] SENT = 32'h5EA1_5EA1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, start = 1'b0, ptr_wr = 1'b0, cond_in = 1'b0;
  logic [AW-1:0] ptr_in = '0;
  logic active, dead, irq, mem_req, mem_we, out_valid, out_last, in_ready;
  logic [AW-1:0] cmd_ptr, mem_addr;
  logic [31:0] mem_wdata, out_data;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic out_ready = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;

  always #5 clk = ~clk;

  dbcmd_engine #(.AW(AW)) u_dbcmd_engine (
    .clk, .rst_n, .run, .start, .ptr_wr, .ptr_in, .cond_in, .active, .dead, .cmd_ptr,
    .irq, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .out_valid, .out_ready, .out_data, .out_last, .in_valid, .in_ready, .in_data, .in_last
  );

  logic [31:0] mem [0:255];
  int total = 0, fails = 0;
  int irq_cnt = 0, beats = 0, lasts = 0, req_cnt = 0;
  logic [31:0] beat_data [0:15];
  bit rdy_mode = 0;
  int phase = 0;
  logic [31:0] src_d [0:7];
  logic        src_l [0:7];
  int src_n = 0, src_idx = 0;
  bit took = 0;

  // memory responder: one-cycle acknowledge
  initial forever @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
      else mem_rdata = mem[mem_addr[9:2]];
    end
  end

  // outgoing sink and monitors
  initial forever @(negedge clk) begin
    phase++;
    out_ready = rdy_mode ? (phase % 3 != 0) : 1'b1;
    #2;
    if (out_valid && out_ready) begin
      if (beats < 16) beat_data[beats] = out_data;
      beats++;
      if (out_last) lasts++;
    end
    if (irq) irq_cnt++;
    if (mem_req) req_cnt++;
  end

  // incoming source
  initial forever @(negedge clk) begin
    if (took) begin src_idx++; took = 0; end
    in_valid = (src_idx < src_n);
    in_data  = (src_idx < 8) ? src_d[src_idx] : '0;
    in_last  = (src_idx < 8) ? src_l[src_idx] : 1'b0;
    #1 took = in_valid && in_ready;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) mem[8'h80 + i] = 32'hA000_0080 + i;
  endtask

  task automatic put_desc(input int base, input logic [15:0] cmd, input logic [15:0] cnt,
                          input logic [31:0] addr, input logic [31:0] dep);
    mem[base/4]   = {cmd, cnt};
    mem[base/4+1] = addr;
    mem[base/4+2] = dep;
    mem[base/4+3] = SENT;
  endtask

  task automatic prep(input logic [15:0] cmd, input logic [15:0] cnt,
                      input logic [31:0] addr, input logic [31:0] dep);
    clear_mem();
    put_desc(0, cmd, cnt, addr, dep);
    put_desc(16, 16'h7000, 0, 0, 0);
    put_desc(32'h100, 16'h7000, 0, 0, 0);
    irq_cnt = 0; beats = 0; lasts = 0;
  endtask

  task automatic launch(input logic [31:0] p);
    @(negedge clk); ptr_in = p; ptr_wr = 1'b1;
    @(negedge clk); ptr_wr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && active; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [15:0] cmd;
    logic [15:0] cnt;
    logic        cnd;
    logic        eirq;
    logic        ebr;
    logic [3:0]  ebeats;
    logic [3:0]  elasts;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h6000, 16'h0024, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
    '{16'h6010, 16'h0024, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0},
    '{16'h6010, 16'h0024, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    '{16'h6020, 16'h0024, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0},
    '{16'h6020, 16'h0024, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
    '{16'h6030, 16'h0024, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0},
    '{16'h6004, 16'h0024, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0},
    '{16'h6008, 16'h0024, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
    '{16'h600C, 16'h0024, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0},
    '{16'h6008, 16'h0024, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0},
    '{16'h0000, 16'h0008, 1'b0, 1'b0, 1'b0, 4'd2, 4'd0},
    '{16'h1000, 16'h0006, 1'b0, 1'b0, 1'b0, 4'd2, 4'd1},
    '{16'h103C, 16'h0004, 1'b1, 1'b1, 1'b1, 4'd1, 4'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 active", {31'b0, active}, 0);
    chk("R1 dead", {31'b0, dead}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 mem_req", {31'b0, mem_req}, 0);
    chk("R1 out_valid/in_ready", {30'b0, out_valid, in_ready}, 0);
    chk("R1 cmd_ptr", cmd_ptr, 0);

    run = 1'b1;
    // R2 R9 R10 R11 R12 R4 table of single-command programs
    for (int v = 0; v < NV; v++) begin
      logic [15:0] st;
      logic [15:0] rs;
      prep(VECS[v].cmd, VECS[v].cnt, 32'h200, 32'h100);
      cond_in = VECS[v].cnd;
      launch(0);
      wait_idle();
      st = 16'h8400 | (VECS[v].ebr ? 16'h0100 : 16'h0) | {15'b0, VECS[v].cnd};
      rs = (VECS[v].cmd[15:12] < 4'd2) ? 16'h0 : VECS[v].cnt;
      chk($sformatf("R9 irq count row %0d", v), irq_cnt, {31'b0, VECS[v].eirq});
      chk($sformatf("R10 next ptr row %0d", v), cmd_ptr, VECS[v].ebr ? 32'h100 : 32'h10);
      chk($sformatf("R11 writeback row %0d", v), mem[3], {st, rs});
      chk($sformatf("R4 beats row %0d", v), beats, {28'b0, VECS[v].ebeats});
      chk($sformatf("R4 last count row %0d", v), lasts, {28'b0, VECS[v].elasts});
      chk($sformatf("R12 stop untouched row %0d", v), mem[7], SENT);
      chk($sformatf("R2 dead low row %0d", v), {31'b0, dead}, 0);
      if (VECS[v].ebeats != 0)
        chk($sformatf("R4 first word row %0d", v), beat_data[0], 32'hA000_0080);
    end

    // R4 back-pressure, four words in order
    prep(16'h1000, 16, 32'h200, 32'h100);
    rdy_mode = 1;
    launch(0); wait_idle();
    rdy_mode = 0;
    chk("R4 backpressure beats", beats, 4);
    for (int k = 0; k < 4; k++) chk("R4 backpressure data", beat_data[k], 32'hA000_0080 + k);
    chk("R4 backpressure last", lasts, 1);

    // R5 input-last ends early on in_last
    prep(16'h3000, 16, 32'h300, 32'h100);
    cond_in = 1'b0;
    src_d[0] = 32'h11; src_l[0] = 0; src_d[1] = 32'h22; src_l[1] = 1;
    src_idx = 0; src_n = 2;
    launch(0); wait_idle();
    chk("R5 in word0", mem[8'hC0], 32'h11);
    chk("R5 in word1", mem[8'hC1], 32'h22);
    chk("R5 in no extra", mem[8'hC2], 0);
    chk("R11 input residual", mem[3], 32'h8400_0008);

    // R5 input-more ignores in_last
    prep(16'h2000, 8, 32'h300, 32'h100);
    src_d[0] = 32'h33; src_l[0] = 1; src_d[1] = 32'h44; src_l[1] = 0;
    src_d[2] = 32'h55; src_l[2] = 0;
    src_idx = 0; src_n = 3;
    launch(0); wait_idle();
    chk("R5 more word1", mem[8'hC1], 32'h44);
    chk("R5 more stops at count", mem[8'hC2], 0);
    chk("R5 more taken", src_idx, 2);
    chk("R11 more residual", mem[3], 32'h8400_0000);
    src_n = 0; src_idx = 0;

    // R6 kill cases
    prep(16'h2000, 8, 32'h0, 32'h100);
    launch(0); wait_idle();
    chk("R6 zero addr dead", {31'b0, dead}, 1);
    chk("R6 zero addr ptr", cmd_ptr, 0);
    chk("R6 zero addr no writeback", mem[3], SENT);
    prep(16'h3400, 8, 32'h300, 32'h100);
    launch(0); wait_idle();
    chk("R6 key4 dead", {31'b0, dead}, 1);
    chk("R6 key4 inactive", {31'b0, active}, 0);
    prep(16'h4000, 4, 32'h340, 32'h1);
    launch(0); wait_idle();
    chk("R6 store key0 dead", {31'b0, dead}, 1);
    chk("R6 store key0 no write", mem[8'hD0], 0);
    prep(16'h8000, 4, 32'h340, 32'h1);
    launch(0); wait_idle();
    chk("R6 opcode8 dead", {31'b0, dead}, 1);
    chk("R6 opcode8 no writeback", mem[3], SENT);

    // R7 store and load word
    prep(16'h4500, 4, 32'h340, 32'hCAFE_F00D);
    launch(0); wait_idle();
    chk("R3 start clears dead", {31'b0, dead}, 0);
    chk("R7 store word", mem[8'hD0], 32'hCAFE_F00D);
    chk("R7 store ptr", cmd_ptr, 32'h10);
    prep(16'h5600, 4, 32'h344, 32'h0);
    mem[8'hD1] = 32'h1234_5678;
    launch(0); wait_idle();
    chk("R7 load into descriptor", mem[2], 32'h1234_5678);
    chk("R11 load residual", mem[3], 32'h8400_0004);

    // R8 wait stall, R3 pointer write ignored while active
    prep(16'h6001, 16'h0024, 32'h200, 32'h100);
    cond_in = 1'b1;
    launch(0);
    repeat (30) @(negedge clk);
    chk("R8 stalled active", {31'b0, active}, 1);
    chk("R8 stalled no writeback", mem[3], SENT);
    chk("R8 stalled ptr", cmd_ptr, 0);
    ptr_in = 32'h80; ptr_wr = 1'b1;
    @(negedge clk); ptr_wr = 1'b0;
    chk("R3 ptr write ignored", cmd_ptr, 0);
    cond_in = 1'b0;
    wait_idle();
    chk("R8 resumed ptr", cmd_ptr, 32'h10);
    chk("R8 resumed writeback", mem[3], 32'h8400_0024);

    // R3 no fetch without run
    prep(16'h6000, 16'h0024, 32'h200, 32'h100);
    run = 1'b0;
    launch(0);
    req_cnt = 0;
    repeat (20) @(negedge clk);
    chk("R3 no request without run", req_cnt, 0);
    chk("R3 active without run", {31'b0, active}, 1);
    run = 1'b1;
    wait_idle();
    chk("R3 runs after run", cmd_ptr, 32'h10);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule